// File: doc/BRIEF.md
# Kd-Tree Ray Traversal Controller

This block walks an axis-aligned binary space partition tree for a single ray and hands each leaf it reaches, with the slice of the ray's parametric interval that falls inside that leaf, to a downstream primitive intersector. Descent is iterative. At each interior node the controller compares the split distance, which an external divider supplies, with the current interval. It then continues into the near child, the far child, or the near child while it saves the far child on a hardware LIFO for later.

Leaves come out in front-to-back order along the ray. The intersector can report hit distances back, so subtrees that start beyond a found hit are never fetched. A ray ends in one of three ways: the last leaf has been handed out with nothing left to resume, a reported hit closes the walk early, or the deferred-subtree store overflows.

Top module: `kdt_walker`

## Requirements
- R1: After reset the controller is idle: busy_o, node_req_o, leaf_valid_o, done_o, early_o and ovf_o are all low.
- R2: When the split distance is strictly greater than the current interval maximum, only the near child is visited, and it keeps the full current interval.
- R3: When the split distance is strictly less than the current interval minimum, only the far child is visited, and it keeps the full current interval.
- R4: In all other cases, including equality with either bound, the near child is visited over [minimum, split], and the far child is deferred with [split, maximum].
- R5: Axis code 0, 1 or 2 selects the x, y or z direction component. The left child lies below the split. A negative component makes the right child the near one, and a zero or positive component makes the left child the near one.
- R6: Deferred far subtrees are resumed in last-in first-out order, so leaves come out front to back.
- R7: A node read raises node_req_o with node_addr_o for one cycle, and the node fields are sampled in the next cycle. Every ray starts at address 0.
- R8: Each leaf reached raises leaf_valid_o for exactly one cycle, with the leaf address and its clipped interval.
- R9: When a leaf has been handled and nothing is deferred, done_o pulses for one cycle. busy_o is low in the cycle after that.
- R10: When a resume is due and a hit distance reported during the ray is strictly less than the resumed interval minimum, the ray ends with done_o and early_o. A hit equal to that minimum does not end the ray.
- R11: A deferral when DEPTH entries are already held ends the ray with done_o and ovf_o and emits no further leaves. Exactly DEPTH deferrals complete normally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ray_start_i | input | 1 | Start a ray (accepted while idle) |
| ray_tmin_i | input | TW | Ray entry distance |
| ray_tmax_i | input | TW | Ray exit distance |
| ray_dir_i | input | 3xDW | Signed direction components x, y, z |
| busy_o | output | 1 | A ray is in progress |
| node_req_o | output | 1 | Node read request |
| node_addr_o | output | AW | Node address |
| node_leaf_i | input | 1 | Fetched node is a leaf |
| node_axis_i | input | 2 | Split axis code of the fetched node |
| node_left_i | input | AW | Child below the split |
| node_right_i | input | AW | Child above the split |
| node_tsplit_i | input | TW | Ray distance to the split plane |
| leaf_valid_o | output | 1 | Leaf emitted this cycle |
| leaf_node_o | output | AW | Leaf address |
| leaf_tmin_o | output | TW | Leaf interval minimum |
| leaf_tmax_o | output | TW | Leaf interval maximum |
| hit_valid_i | input | 1 | Intersector reports a hit |
| hit_t_i | input | TW | Hit distance |
| done_o | output | 1 | Ray finished this cycle |
| early_o | output | 1 | Finish caused by a closer hit |
| ovf_o | output | 1 | Finish caused by deferral overflow |

## Verification
The bench sweeps a three-level tree over every split placement below, at or above each interval bound, for all 27 sign patterns of the direction. A design that misranks equality would drop the degenerate near or far visit. One that mishandles the zero sign would swap the leaf order. One that clips the wrong bound would emit wrong intervals. Two chains, 32 and 33 deferrals deep, separate a correct capacity limit from an off-by-one that either aborts too soon or wraps the store silently. A hit below and then exactly at the deferred minimum shows whether the early-exit comparison is strict.

// File: rtl/kdt_pkg.sv
package kdt_pkg;
  typedef enum logic [1:0] {ST_IDLE, ST_FETCH, ST_EVAL, ST_POP} kdt_state_e;
  typedef enum logic [1:0] {CLS_NEAR, CLS_FAR, CLS_BOTH} kdt_cls_e;
endpackage

// File: rtl/kdt_lifo.sv
module kdt_lifo #(
  parameter int W     = 40,
  parameter int DEPTH = 32
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         clr_i,
  input  logic         push_i,
  input  logic         pop_i,
  input  logic [W-1:0] din_i,
  output logic [W-1:0] dout_o,
  output logic         empty_o,
  output logic         full_o
);
  localparam int PW = $clog2(DEPTH + 1);
  localparam int IW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [W-1:0]  mem [DEPTH];
  logic [PW-1:0] cnt_q;
  logic [PW-1:0] top_idx;

  assign empty_o = (cnt_q == '0);
  assign full_o  = (cnt_q == PW'(DEPTH));
  assign top_idx = cnt_q - 1'b1;
  assign dout_o  = mem[top_idx[IW-1:0]];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                 cnt_q <= '0;
    else if (clr_i)              cnt_q <= '0;
    else if (push_i && !full_o)  cnt_q <= cnt_q + 1'b1;
    else if (pop_i && !empty_o)  cnt_q <= cnt_q - 1'b1;
  end

  always_ff @(posedge clk_i) begin
    if (push_i && !full_o && !clr_i) mem[cnt_q[IW-1:0]] <= din_i;
  end
endmodule

// File: rtl/kdt_split_sel.sv
module kdt_split_sel import kdt_pkg::*; #(
  parameter int AW = 8,
  parameter int TW = 16
) (
  input  logic [TW-1:0] tmin_i,
  input  logic [TW-1:0] tmax_i,
  input  logic [TW-1:0] tsplit_i,
  input  logic [1:0]    axis_i,
  input  logic [2:0]    dir_neg_i,
  input  logic [AW-1:0] left_i,
  input  logic [AW-1:0] right_i,
  output kdt_cls_e      cls_o,
  output logic [AW-1:0] near_o,
  output logic [AW-1:0] far_o
);
  logic neg;

  always_comb begin
    case (axis_i)
      2'd0:    neg = dir_neg_i[0];
      2'd1:    neg = dir_neg_i[1];
      2'd2:    neg = dir_neg_i[2];
      default: neg = 1'b0;
    endcase
  end

  assign near_o = neg ? right_i : left_i;
  assign far_o  = neg ? left_i  : right_i;

  always_comb begin
    if (tsplit_i > tmax_i)      cls_o = CLS_NEAR;
    else if (tsplit_i < tmin_i) cls_o = CLS_FAR;
    else                        cls_o = CLS_BOTH;
  end
endmodule

// File: rtl/kdt_walker.sv
module kdt_walker import kdt_pkg::*; #(
  parameter int AW    = 8,
  parameter int TW    = 16,
  parameter int DW    = 16,
  parameter int DEPTH = 32
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               ray_start_i,
  input  logic [TW-1:0]      ray_tmin_i,
  input  logic [TW-1:0]      ray_tmax_i,
  input  logic [2:0][DW-1:0] ray_dir_i,
  output logic               busy_o,
  output logic               node_req_o,
  output logic [AW-1:0]      node_addr_o,
  input  logic               node_leaf_i,
  input  logic [1:0]         node_axis_i,
  input  logic [AW-1:0]      node_left_i,
  input  logic [AW-1:0]      node_right_i,
  input  logic [TW-1:0]      node_tsplit_i,
  output logic               leaf_valid_o,
  output logic [AW-1:0]      leaf_node_o,
  output logic [TW-1:0]      leaf_tmin_o,
  output logic [TW-1:0]      leaf_tmax_o,
  input  logic               hit_valid_i,
  input  logic [TW-1:0]      hit_t_i,
  output logic               done_o,
  output logic               early_o,
  output logic               ovf_o
);
  localparam int EW = AW + 2 * TW;

  kdt_state_e    state_q;
  logic [AW-1:0] cur_q;
  logic [TW-1:0] tmin_q, tmax_q, best_q;
  logic          hit_seen_q;
  logic [2:0]    dir_neg_q;

  kdt_cls_e      cls;
  logic [AW-1:0] near_idx, far_idx;
  logic          stk_push, stk_pop, stk_clr, stk_empty, stk_full;
  logic [EW-1:0] stk_top;
  logic [AW-1:0] top_node;
  logic [TW-1:0] top_tmin, top_tmax;
  logic          hit_any, stop_now, split_both;
  logic [TW-1:0] hit_eff;

  kdt_split_sel #(.AW(AW), .TW(TW)) u_sel (
    .tmin_i   (tmin_q),
    .tmax_i   (tmax_q),
    .tsplit_i (node_tsplit_i),
    .axis_i   (node_axis_i),
    .dir_neg_i(dir_neg_q),
    .left_i   (node_left_i),
    .right_i  (node_right_i),
    .cls_o    (cls),
    .near_o   (near_idx),
    .far_o    (far_idx)
  );

  kdt_lifo #(.W(EW), .DEPTH(DEPTH)) u_stk (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (stk_clr),
    .push_i (stk_push),
    .pop_i  (stk_pop),
    .din_i  ({far_idx, node_tsplit_i, tmax_q}),
    .dout_o (stk_top),
    .empty_o(stk_empty),
    .full_o (stk_full)
  );

  assign {top_node, top_tmin, top_tmax} = stk_top;

  // closest hit so far, including one arriving this cycle
  assign hit_any = hit_seen_q || hit_valid_i;
  assign hit_eff = (hit_valid_i && (!hit_seen_q || hit_t_i < best_q)) ? hit_t_i : best_q;
  assign stop_now = hit_any && (hit_eff < top_tmin);

  assign split_both = (state_q == ST_EVAL) && !node_leaf_i && (cls == CLS_BOTH);
  assign stk_clr    = (state_q == ST_IDLE) && ray_start_i;
  assign stk_push   = split_both && !stk_full;
  assign stk_pop    = (state_q == ST_POP) && !stk_empty && !stop_now;

  assign busy_o       = (state_q != ST_IDLE);
  assign node_req_o   = (state_q == ST_FETCH);
  assign node_addr_o  = cur_q;
  assign leaf_valid_o = (state_q == ST_EVAL) && node_leaf_i;
  assign leaf_node_o  = cur_q;
  assign leaf_tmin_o  = tmin_q;
  assign leaf_tmax_o  = tmax_q;
  assign ovf_o        = split_both && stk_full;
  assign early_o      = (state_q == ST_POP) && !stk_empty && stop_now;
  assign done_o       = ((state_q == ST_POP) && (stk_empty || stop_now)) || ovf_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q    <= ST_IDLE;
      cur_q      <= '0;
      tmin_q     <= '0;
      tmax_q     <= '0;
      best_q     <= '0;
      hit_seen_q <= 1'b0;
      dir_neg_q  <= '0;
    end else begin
      if (state_q != ST_IDLE && hit_valid_i) begin
        best_q     <= hit_eff;
        hit_seen_q <= 1'b1;
      end
      unique case (state_q)
        ST_IDLE: if (ray_start_i) begin
          cur_q      <= '0;
          tmin_q     <= ray_tmin_i;
          tmax_q     <= ray_tmax_i;
          hit_seen_q <= 1'b0;
          for (int a = 0; a < 3; a++) dir_neg_q[a] <= ray_dir_i[a][DW-1];
          state_q    <= ST_FETCH;
        end
        ST_FETCH: state_q <= ST_EVAL;
        ST_EVAL: begin
          if (node_leaf_i) begin
            state_q <= ST_POP;
          end else begin
            unique case (cls)
              CLS_NEAR: begin cur_q <= near_idx; state_q <= ST_FETCH; end
              CLS_FAR:  begin cur_q <= far_idx;  state_q <= ST_FETCH; end
              default: begin
                if (stk_full) begin
                  state_q <= ST_IDLE;
                end else begin
                  cur_q   <= near_idx;
                  tmax_q  <= node_tsplit_i;
                  state_q <= ST_FETCH;
                end
              end
            endcase
          end
        end
        ST_POP: begin
          if (stk_empty || stop_now) begin
            state_q <= ST_IDLE;
          end else begin
            cur_q   <= top_node;
            tmin_q  <= top_tmin;
            tmax_q  <= top_tmax;
            state_q <= ST_FETCH;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/kdt_walker_chk.sv
module kdt_walker_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic ray_start_i,
  input logic busy_o,
  input logic node_req_o,
  input logic leaf_valid_o,
  input logic done_o,
  input logic early_o,
  input logic ovf_o
);
  a_r1_idle_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> (!node_req_o && !leaf_valid_o && !done_o));
  a_r7_req_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    node_req_o |=> !node_req_o);
  a_r8_leaf_no_req: assert property (@(posedge clk_i) disable iff (!rst_ni)
    leaf_valid_o |=> !leaf_valid_o);
  a_r9_done_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !busy_o);
  a_r9_start_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ray_start_i && !busy_o) |=> busy_o);
  a_r10_early_done: assert property (@(posedge clk_i) disable iff (!rst_ni)
    early_o |-> done_o);
  a_r11_ovf_done: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ovf_o |-> (done_o && !early_o));
endmodule

bind kdt_walker kdt_walker_chk u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .ray_start_i (ray_start_i),
  .busy_o      (busy_o),
  .node_req_o  (node_req_o),
  .leaf_valid_o(leaf_valid_o),
  .done_o      (done_o),
  .early_o     (early_o),
  .ovf_o       (ovf_o)
);

// File: tb/sim_kdt_walker.sv
module sim_kdt_walker;
  localparam int AW = 8;
  localparam int TW = 16;
  localparam int DW = 16;
  localparam int DEPTH = 32;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #10 clk = ~clk;

  logic               ray_start;
  logic [TW-1:0]      ray_tmin, ray_tmax;
  logic [2:0][DW-1:0] ray_dir;
  logic               busy, node_req, leaf_valid, done, early, ovf;
  logic [AW-1:0]      node_addr, leaf_node;
  logic [TW-1:0]      leaf_tmin, leaf_tmax;
  logic               hit_valid;
  logic [TW-1:0]      hit_t;

  logic          t_leaf [256];
  logic [1:0]    t_axis [256];
  logic [AW-1:0] t_left [256];
  logic [AW-1:0] t_right[256];
  logic [TW-1:0] t_split[256];
  logic [AW-1:0] rd_addr;

  always_ff @(posedge clk) if (node_req) rd_addr <= node_addr;

  kdt_walker #(.AW(AW), .TW(TW), .DW(DW), .DEPTH(DEPTH)) u0 (
    .clk_i(clk), .rst_ni(rst_n),
    .ray_start_i(ray_start), .ray_tmin_i(ray_tmin), .ray_tmax_i(ray_tmax), .ray_dir_i(ray_dir),
    .busy_o(busy), .node_req_o(node_req), .node_addr_o(node_addr),
    .node_leaf_i(t_leaf[rd_addr]), .node_axis_i(t_axis[rd_addr]),
    .node_left_i(t_left[rd_addr]), .node_right_i(t_right[rd_addr]),
    .node_tsplit_i(t_split[rd_addr]),
    .leaf_valid_o(leaf_valid), .leaf_node_o(leaf_node),
    .leaf_tmin_o(leaf_tmin), .leaf_tmax_o(leaf_tmax),
    .hit_valid_i(hit_valid), .hit_t_i(hit_t),
    .done_o(done), .early_o(early), .ovf_o(ovf)
  );

  int checks = 0, fails = 0;
  int exp_n, got_n;
  int exp_id[64], exp_lo[64], exp_hi[64];
  bit exp_ovf, got_done, got_ovf, got_early;

  task automatic chk(input bit ok, input string req, input int act, input int expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  // leaf and completion monitor
  always @(negedge clk) begin
    if (rst_n && leaf_valid) begin
      if (got_n < exp_n) begin
        chk(leaf_node == AW'(exp_id[got_n]), "R6 R8 leaf id", int'(leaf_node), exp_id[got_n]);
        chk(leaf_tmin == TW'(exp_lo[got_n]), "R2 R3 R4 leaf tmin", int'(leaf_tmin), exp_lo[got_n]);
        chk(leaf_tmax == TW'(exp_hi[got_n]), "R2 R3 R4 leaf tmax", int'(leaf_tmax), exp_hi[got_n]);
      end else begin
        chk(1'b0, "R9 extra leaf", got_n + 1, exp_n);
      end
      got_n++;
    end
    if (rst_n && done) begin
      got_done  = 1'b1;
      got_ovf   = ovf;
      got_early = early;
    end
  end

  task automatic clear_tree();
    for (int i = 0; i < 256; i++) begin
      t_leaf[i] = 1'b1; t_axis[i] = 2'd0; t_left[i] = '0; t_right[i] = '0; t_split[i] = '0;
    end
  endtask

  task automatic set_node(input int n, input int ax, input int l, input int r, input int ts);
    t_leaf[n] = 1'b0; t_axis[n] = 2'(ax); t_left[n] = AW'(l); t_right[n] = AW'(r); t_split[n] = TW'(ts);
  endtask

  // expected leaf sequence from the requirements
  task automatic ref_walk(input logic [2:0] neg, input int lo0, input int hi0);
    int sn[DEPTH], slo[DEPTH], shi[DEPTH];
    int sp = 0, cur = 0, lo = lo0, hi = hi0;
    exp_n = 0; exp_ovf = 1'b0;
    for (int step = 0; step < 2000; step++) begin
      if (t_leaf[cur]) begin
        exp_id[exp_n] = cur; exp_lo[exp_n] = lo; exp_hi[exp_n] = hi; exp_n++;
        if (sp == 0) break;
        sp--; cur = sn[sp]; lo = slo[sp]; hi = shi[sp];
      end else begin
        int ts = int'(t_split[cur]);
        bit ng = (t_axis[cur] < 3) ? neg[t_axis[cur]] : 1'b0;
        int nr = ng ? int'(t_right[cur]) : int'(t_left[cur]);
        int fr = ng ? int'(t_left[cur]) : int'(t_right[cur]);
        if (ts > hi) cur = nr;
        else if (ts < lo) cur = fr;
        else begin
          if (sp == DEPTH) begin exp_ovf = 1'b1; break; end
          sn[sp] = fr; slo[sp] = ts; shi[sp] = hi; sp++;
          cur = nr; hi = ts;
        end
      end
    end
  endtask

  task automatic launch(input int dcode, input int lo, input int hi);
    logic [2:0] neg;
    for (int a = 0; a < 3; a++) begin
      int v = (dcode / (a == 0 ? 1 : (a == 1 ? 3 : 9))) % 3;
      ray_dir[a] = (v == 0) ? 16'hFFFD : ((v == 1) ? 16'h0000 : 16'h0003);
      neg[a] = (v == 0);
    end
    ref_walk(neg, lo, hi);
    got_n = 0; got_done = 1'b0; got_ovf = 1'b0; got_early = 1'b0;
    ray_tmin = TW'(lo); ray_tmax = TW'(hi);
    @(negedge clk); ray_start = 1'b1;
    @(negedge clk); ray_start = 1'b0;
  endtask

  task automatic finish_ray(input string tag);
    for (int w = 0; w < 3000 && !got_done; w++) @(negedge clk);
    @(negedge clk);
    chk(got_done, "R9 done seen", int'(got_done), 1);
    chk(!busy, "R9 idle after done", int'(busy), 0);
    chk(got_n == exp_n, tag, got_n, exp_n);
    chk(got_ovf == exp_ovf, "R11 overflow flag", int'(got_ovf), int'(exp_ovf));
  endtask

  initial begin
    for (int c = 0; c < 200000; c++) @(posedge clk);
    chk(1'b0, "watchdog", 0, 1);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    int sv[5];
    sv[0] = 5; sv[1] = 10; sv[2] = 20; sv[3] = 30; sv[4] = 40;
    ray_start = 1'b0; ray_tmin = '0; ray_tmax = '0; ray_dir = '0;
    hit_valid = 1'b0; hit_t = '0; exp_n = 0; got_n = 0;
    clear_tree();
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(!busy && !node_req && !leaf_valid && !done && !early && !ovf, "R1 reset idle",
        int'({busy, node_req, leaf_valid, done, early, ovf}), 0);
    rst_n = 1'b1;
    @(negedge clk);

    // R7 root fetch, R5 zero direction picks left as near
    clear_tree();
    set_node(0, 0, 1, 2, 20);
    launch(13, 10, 30);
    chk(node_req && node_addr == 0, "R7 root read", int'(node_addr), 0);
    finish_ray("R5 zero dir leaf count");

    // sweep: three interior nodes, all split placements and direction signs
    clear_tree();
    for (int a = 0; a < 5; a++)
      for (int b = 0; b < 5; b++)
        for (int c = 0; c < 5; c++) begin
          set_node(0, 0, 1, 2, sv[a]);
          set_node(1, 1, 3, 4, sv[b]);
          set_node(2, 2, 5, 6, sv[c]);
          for (int d = 0; d < 27; d++) begin
            launch(d, 10, 30);
            finish_ray("R2 R3 R4 R5 R6 leaf count");
          end
        end

    // R11: exactly DEPTH deferrals complete, one more overflows
    for (int k = DEPTH; k <= DEPTH + 1; k++) begin
      clear_tree();
      for (int i = 0; i < k; i++) set_node(i, 0, i + 1, 200, 20);
      launch(26, 10, 30);
      finish_ray("R11 chain leaf count");
      chk(got_ovf == (k > DEPTH), "R11 capacity boundary", int'(got_ovf), int'(k > DEPTH));
    end

    // R10: hit below deferred minimum ends early, hit equal does not
    for (int h = 0; h < 2; h++) begin
      clear_tree();
      set_node(0, 0, 1, 2, 20);
      launch(26, 10, 30);
      if (h == 0) exp_n = 1;
      for (int w = 0; w < 100 && !leaf_valid; w++) @(negedge clk);
      hit_valid = 1'b1; hit_t = (h == 0) ? 16'd15 : 16'd20;
      @(negedge clk);
      hit_valid = 1'b0;
      for (int w = 0; w < 100 && !got_done; w++) @(negedge clk);
      @(negedge clk);
      chk(got_n == exp_n, "R10 leaves after hit", got_n, exp_n);
      chk(got_early == (h == 0), "R10 early flag", int'(got_early), int'(h == 0));
      chk(!busy, "R9 idle after early check", int'(busy), 0);
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule